// File: doc/BRIEF.md
# EEPROM Page Latch with Timed Commit

This block sits between a serial write engine and a nonvolatile byte array. The engine first loads a start address. It then streams data bytes in, and each byte lands in a 16-slot page latch at the slot named by the low four bits of the pointer. After each byte, only those low four bits advance. The page number stays fixed, so a burst longer than one page wraps around and overwrites slots it wrote earlier. A single-byte write is simply a burst of length one.

A commit pulse starts one programmed write cycle. The block holds `busy` high for `TWR_CYCLES` clocks. On the last clock of that window it stores every loaded slot into the array in one step and leaves the unloaded bytes of the page untouched. The array comes out of reset erased, with every byte at 0xFF. A combinational read port lets the surrounding logic, and the bench, observe the stored contents.

Data enters over a valid/ready handshake. A byte is taken only on a cycle where `din_valid` and `din_ready` are both high. The producer must hold a byte and wait while `din_ready` is low. `din_ready` drops while busy, while an address load or commit is presented, and while a protected page is selected. The commit and protect inputs are plain level or pulse controls.

Top module: `eepb_page_writer`

## Requirements
- R1: After reset `busy` is 0, `ptr` is 0, and every array byte reads 0xFF.
- R2: `addr_load` while idle sets `ptr` to `addr_in`. While busy it is ignored and `ptr` keeps its value.
- R3: Each accepted byte (`din_valid` and `din_ready` high at a clock edge) increments `ptr[3:0]` modulo 16 and leaves `ptr[ADDR_W-1:4]` unchanged.
- R4: When more than 16 bytes are accepted before a commit, the later bytes replace the earlier ones in the same slots, and only the newest value per slot is stored.
- R5: A write cycle stores exactly the slots loaded since the last address load into page `ptr[ADDR_W-1:4]`. All other array bytes keep their contents.
- R6: An accepted commit raises `busy` on the next clock, and `busy` stays high for exactly `TWR_CYCLES` cycles. `din_ready` is 0 whenever `busy` is 1.
- R7: A commit presented while busy, or while no slot is loaded, has no effect. A commit while busy does not lengthen the window.
- R8: When `wp` is 1 and `ptr[ADDR_W-1]` is 1 (upper half), `din_ready` is 0 and no byte is latched. The lower half is unaffected by `wp`.
- R9: `arr_we` is high for exactly one cycle, the last busy cycle. During that cycle `arr_page` gives the page and `arr_mask` bit i is 1 exactly when slot i is loaded.
- R10: Loaded-slot marks clear when a write cycle completes and when a new address is loaded. A later commit with no new bytes is therefore ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address (pulse) |
| addr_in | input | ADDR_W | Start address |
| din_valid | input | 1 | Data byte offered |
| din_ready | output | 1 | Data byte can be taken |
| din | input | 8 | Data byte |
| commit | input | 1 | Start write cycle (pulse) |
| wp | input | 1 | Protect upper half of the array |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_page | output | ADDR_W-4 | Page being written |
| arr_mask | output | 16 | Slots being written |
| ptr | output | ADDR_W | Current address pointer |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
The following are checked on every cycle: the pointer step that keeps the page bits fixed, `din_ready` held low while busy or protected, a busy window that starts only from a commit and lasts exactly `TWR_CYCLES`, and a single write strobe with a non-empty mask at the end of the window. Other behaviour shows only in the bench scenarios, which compare the full array against a reference model after each cycle. These cover wrap-around overwriting, partial pages leaving neighbouring bytes intact, protected writes leaving the upper half untouched, and commits or loads dropped while busy.

// File: rtl/eepb_pkg.sv
package eepb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/eepb_page_latch.sv
module eepb_page_latch
  import eepb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  localparam int NSLOT = 1 << OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_en,
  input  byte_t             wr_data,
  input  logic              clear,
  output logic [ADDR_W-1:0] ptr,
  output byte_t [NSLOT-1:0] slot_data,
  output logic [NSLOT-1:0]  slot_vld
);
  logic [OFF_W-1:0] off;
  assign off = ptr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      slot_vld <= '0;
    end else if (load) begin
      ptr      <= load_addr;
      slot_vld <= '0;
    end else if (clear) begin
      slot_vld <= '0;
    end else if (wr_en) begin
      slot_vld[off]     <= 1'b1;
      ptr[OFF_W-1:0]    <= off + OFF_W'(1);
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_data[s] <= '0;
      else if (wr_en && !load && !clear && off == OFF_W'(s))
        slot_data[s] <= wr_data;
    end
  end
endmodule

// File: rtl/eepb_wr_timer.sv
module eepb_wr_timer #(
  parameter int TWR_CYCLES = 12,
  localparam int CW = $clog2(TWR_CYCLES + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt - CW'(1);
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(TWR_CYCLES - 1);
    end
  end
endmodule

// File: rtl/eepb_array.sv
module eepb_array
  import eepb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  localparam int NSLOT = 1 << OFF_W,
  localparam int DEPTH = 1 << ADDR_W
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-OFF_W-1:0] page,
  input  logic [NSLOT-1:0]        mask,
  input  byte_t [NSLOT-1:0]       wdata,
  input  logic [ADDR_W-1:0]       rd_addr,
  output byte_t                   rd_data
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
    end else if (we) begin
      for (int s = 0; s < NSLOT; s++)
        if (mask[s]) mem[{page, OFF_W'(s)}] <= wdata[s];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eepb_page_writer.sv
module eepb_page_writer
  import eepb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFF_W      = 4,
  parameter int TWR_CYCLES = 12,
  localparam int NSLOT = 1 << OFF_W
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addr_load,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    din_valid,
  output logic                    din_ready,
  input  logic [7:0]              din,
  input  logic                    commit,
  input  logic                    wp,
  output logic                    busy,
  output logic                    arr_we,
  output logic [ADDR_W-OFF_W-1:0] arr_page,
  output logic [NSLOT-1:0]        arr_mask,
  output logic [ADDR_W-1:0]       ptr,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  byte_t [NSLOT-1:0] slot_data;
  logic  [NSLOT-1:0] slot_vld;
  logic load_ok, accept, commit_ok, prot_hit, done;

  assign prot_hit  = wp && ptr[ADDR_W-1];
  assign load_ok   = addr_load && !busy;
  assign din_ready = !busy && !addr_load && !commit && !prot_hit;
  assign accept    = din_valid && din_ready;
  assign commit_ok = commit && !busy && !addr_load && (|slot_vld);

  eepb_page_latch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_addr(addr_in),
    .wr_en(accept), .wr_data(din), .clear(done),
    .ptr(ptr), .slot_data(slot_data), .slot_vld(slot_vld)
  );

  eepb_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_ok), .busy(busy), .done(done)
  );

  assign arr_we   = done;
  assign arr_page = ptr[ADDR_W-1:OFF_W];
  assign arr_mask = slot_vld;

  eepb_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(done), .page(arr_page), .mask(slot_vld),
    .wdata(slot_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/eepb_checker.sv
module eepb_checker #(
  parameter int ADDR_W     = 8,
  parameter int OFF_W      = 4,
  parameter int TWR_CYCLES = 12,
  localparam int NSLOT = 1 << OFF_W
)(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_in,
  input logic              din_valid,
  input logic              din_ready,
  input logic              commit,
  input logic              wp,
  input logic              busy,
  input logic              arr_we,
  input logic [NSLOT-1:0]  arr_mask,
  input logic [ADDR_W-1:0] ptr
);
  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else           run_len <= '0;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !busy) |=> (ptr == $past(addr_in)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && din_ready) |=>
      (ptr[ADDR_W-1:OFF_W] == $past(ptr[ADDR_W-1:OFF_W])) &&
      (ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + OFF_W'(1))));

  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !din_ready);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  p_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 32'(TWR_CYCLES)));

  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit && arr_mask == '0) |=> !busy);

  p_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && ptr[ADDR_W-1]) |-> !din_ready);

  p_we_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (busy && arr_mask != '0) ##1 !busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arr_we) |=> busy);
endmodule

bind eepb_page_writer eepb_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TWR_CYCLES(TWR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
  .din_valid(din_valid), .din_ready(din_ready), .commit(commit), .wp(wp),
  .busy(busy), .arr_we(arr_we), .arr_mask(arr_mask), .ptr(ptr)
);

// File: tb/test_eepb_page_writer.sv
`timescale 1ns/1ps
module test_eepb_page_writer;
  localparam int AW = 8;
  localparam int TWR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, din_valid = 1'b0, commit = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr_in = '0, rd_addr = '0;
  logic [7:0] din = '0;
  logic din_ready, busy, arr_we;
  logic [3:0] arr_page;
  logic [15:0] arr_mask;
  logic [AW-1:0] ptr;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] lat [16];
  logic [15:0] lv;
  logic [7:0] rptr;

  always #2.5 clk = ~clk;

  eepb_page_writer i_eepb_page_writer (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .din_valid(din_valid), .din_ready(din_ready), .din(din), .commit(commit),
    .wp(wp), .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
    .arr_mask(arr_mask), .ptr(ptr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
    rptr = a; lv = '0;
  endtask

  task automatic send(input logic [7:0] d);
    logic exp_rdy;
    exp_rdy = !(wp && rptr[7]);
    @(negedge clk); din_valid = 1'b1; din = d;
    #1 chk("R8 din_ready", int'(din_ready), int'(exp_rdy));
    if (exp_rdy) begin
      lat[rptr[3:0]] = d; lv[rptr[3:0]] = 1'b1;
      rptr[3:0] = rptr[3:0] + 4'd1;
    end
    @(negedge clk); din_valid = 1'b0;
  endtask

  task automatic compare_mem(input string req);
    int bad_a, bad_e;
    bad_a = 0; bad_e = 0;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #1;
      if (rd_data !== ref_mem[a] && bad_a == bad_e) begin
        bad_a = int'(rd_data) + 256 * a + 65536; bad_e = int'(ref_mem[a]) + 256 * a + 65536;
      end
    end
    chk(req, bad_a, bad_e);
  endtask

  task automatic run_commit(input bit poke);
    int n, wecnt;
    logic [15:0] m_s;
    logic [3:0] p_s;
    logic [7:0] ptr0;
    logic exp_start;
    exp_start = (lv != 16'd0);
    ptr0 = ptr;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    #1 chk(exp_start ? "R6 busy start" : "R7 R10 commit ignored", int'(busy), int'(exp_start));
    if (!exp_start) return;
    n = 0; wecnt = 0; m_s = '0; p_s = '0;
    while (busy && n < 1000) begin
      if (arr_we) begin wecnt++; m_s = arr_mask; p_s = arr_page; end
      if (n == 2) chk("R6 ready low", int'(din_ready), 0);
      commit    = poke && (n == 3);
      addr_load = poke && (n == 5);
      addr_in   = 8'h00;
      n++;
      @(negedge clk); #1;
    end
    commit = 1'b0; addr_load = 1'b0;
    chk("R6 busy length", n, TWR);
    chk("R9 strobe count", wecnt, 1);
    chk("R9 mask", int'(m_s), int'(lv));
    chk("R9 page", int'(p_s), int'(rptr[7:4]));
    if (poke) chk("R2 load ignored while busy", int'(ptr), int'(ptr0));
    for (int s = 0; s < 16; s++)
      if (lv[s]) ref_mem[{rptr[7:4], 4'(s)}] = lat[s];
    lv = '0;
    compare_mem("R5 array contents");
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    for (int a = 0; a < 256; a++) ref_mem[a] = 8'hFF;
    for (int s = 0; s < 16; s++) lat[s] = 8'h00;
    lv = '0; rptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 ptr", int'(ptr), 0);
    compare_mem("R1 erased array");

    // single byte
    do_load(8'h10);
    chk("R2 ptr load", int'(ptr), 8'h10);
    send(8'hA5);
    run_commit(1'b0);

    // wrap overwrite: 20 bytes from 0x35
    do_load(8'h35);
    for (int i = 0; i < 20; i++) send(8'(i * 3 + 1));
    chk("R3 R4 wrapped ptr", int'(ptr), 8'h39);
    run_commit(1'b0);

    // commit with nothing loaded after completion
    run_commit(1'b0);

    // new load clears marks
    do_load(8'h20); send(8'h77); do_load(8'h40);
    run_commit(1'b0);
    compare_mem("R10 nothing written");

    // protected upper half
    wp = 1'b1;
    do_load(8'h90); send(8'h11); send(8'h12);
    chk("R8 ptr unchanged", int'(ptr), 8'h90);
    run_commit(1'b0);
    compare_mem("R8 upper half untouched");
    do_load(8'h22); send(8'h33); send(8'h44);
    run_commit(1'b0);
    wp = 1'b0;

    // commit and load during busy
    do_load(8'h60);
    for (int i = 0; i < 4; i++) send(8'(8'hC0 + i));
    run_commit(1'b1);

    // constrained random bursts
    for (int it = 0; it < 25; it++) begin
      int cnt;
      wp = 1'($urandom % 2);
      do_load(8'($urandom % 256));
      cnt = 1 + int'($urandom % 20);
      for (int i = 0; i < cnt; i++) send(8'($urandom));
      run_commit(1'b0);
    end
    wp = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule